// File: doc/BRIEF.md
# Pin I/O Controller with Alternate-Function Routing

This block manages a bank of general-purpose pins (32 by default) through a flat file of seventeen word-wide registers. Each register holds one bit per pin, and bit position `i` always refers to pin `i`. Software sets the direction of each pin, the level it drives, pull-up and drive-strength pad controls, an output inversion mask, and per-pin interrupt conditions. Pad inputs are synchronised and then sampled into a readable input-value word.

Each pin can also be released from software control and handed to one of two alternate peripherals. A per-pin enable bit chooses between software control and the alternate path. A per-pin select bit chooses which peripheral drives the pin. The inversion mask acts after this choice, so it applies to both software and peripheral output.

The bus is a plain single-cycle port. A write strobe stores the data word at the register indexed by `bus_addr[6:2]`. Read data is combinational from the address. Reads have no side effects.

Top module: `pinio_ctrl`

## Requirements
- R1: While reset is asserted, every register reads 0 and `pad_out`, `pad_oe`, `pad_pull`, `pad_drive` and `irq` are all 0.
- R2: The register index is `bus_addr[6:2]`, and `bus_addr[1:0]` is ignored. The index map is:
  - 0 input value, 1 input enable, 2 output enable, 3 output value
  - 4 pull-up, 5 drive strength
  - 6 rise enable, 7 rise pending, 8 fall enable, 9 fall pending
  - 10 high enable, 11 high pending, 12 low enable, 13 low pending
  - 14 alternate enable, 15 alternate select, 16 output invert

  Indices 17 and above read 0, and writes to them change nothing.
- R3: Registers 1–6, 8, 10, 12 and 14–16 store every bit of a written word and read it back unchanged, whether or not the pin has a pad.
- R4: A `pad_in` level present before rising edge k appears in register 0 after edge k+2 (two synchroniser flops, then the sample register). Register 0 reads 0 for pins whose input-enable bit is 0. Writes to register 0 are ignored.
- R5: `pad_out[i]` is the selected source XOR the output-invert bit. The source is output value when the alternate-enable bit is 0. When it is 1, the source is `alt0_out` if the select bit is 0 and `alt1_out` if it is 1.
- R6: `pad_oe[i]` is the output-enable register bit when the alternate-enable bit is 0. When it is 1, it is `alt0_oe` or `alt1_oe`, chosen by the select bit.
- R7: `pad_pull` and `pad_drive` equal registers 4 and 5.
- R8: A rise-pending bit sets on the edge where the sampled input-value bit goes 0→1. A fall-pending bit sets on the edge where it goes 1→0.
- R9: A high-pending bit sets on every edge after which the sampled bit is 1. A low-pending bit sets on every edge after which it is 0.
- R10: Writing a 1 to a pending bit clears it, and writing a 0 leaves it unchanged. If a set condition occurs in the same cycle as the clear, the bit stays set.
- R11: `irq[i]` is 1 exactly when some pending bit of pin i is 1 and its matching enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 7 | Byte address; bits 6:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| pad_pull | output | 32 | Pull-up enables |
| pad_drive | output | 32 | Drive-strength selects |
| alt0_out | input | 32 | Output levels from alternate function 0 |
| alt0_oe | input | 32 | Output enables from alternate function 0 |
| alt1_out | input | 32 | Output levels from alternate function 1 |
| alt1_oe | input | 32 | Output enables from alternate function 1 |
| irq | output | 32 | Per-pin interrupt request |

## Verification
A corrupted configuration bit shows at the pad outputs in the same cycle, because the routing after the register file is purely combinational. A corrupted pending or enable bit shows on `irq` in the cycle after it is stored. A fault in the input path shows in the input-value read-back exactly three edges after a pad change. A fault in edge or level detection shows in the pending read-back on that same edge. Because every output and the read data are compared each cycle against a behavioural model, a divergence is reported in the first cycle it becomes visible.

// File: rtl/pinio_pkg.sv
`timescale 1ns/1ps
package pinio_pkg;
    localparam int NUM_REGS = 17;

    // Register order is visible to software: keep it fixed.
    typedef enum logic [4:0] {
        RG_IN_VAL  = 5'd0,
        RG_IN_EN   = 5'd1,
        RG_OUT_EN  = 5'd2,
        RG_OUT_VAL = 5'd3,
        RG_PULL    = 5'd4,
        RG_DRIVE   = 5'd5,
        RG_RISE_IE = 5'd6,
        RG_RISE_IP = 5'd7,
        RG_FALL_IE = 5'd8,
        RG_FALL_IP = 5'd9,
        RG_HIGH_IE = 5'd10,
        RG_HIGH_IP = 5'd11,
        RG_LOW_IE  = 5'd12,
        RG_LOW_IP  = 5'd13,
        RG_ALT_EN  = 5'd14,
        RG_ALT_SEL = 5'd15,
        RG_OUT_INV = 5'd16
    } reg_idx_e;
endpackage

// File: rtl/pinio_sync.sv
`timescale 1ns/1ps
module pinio_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/pinio_regs.sv
`timescale 1ns/1ps
module pinio_regs
    import pinio_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      in_sync,
    output logic [N-1:0]      out_en,
    output logic [N-1:0]      out_val,
    output logic [N-1:0]      pull_en,
    output logic [N-1:0]      drive_sel,
    output logic [N-1:0]      alt_en,
    output logic [N-1:0]      alt_sel,
    output logic [N-1:0]      out_inv,
    output logic [N-1:0]      irq
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [NUM_REGS-1:0][N-1:0] bank;
    } regs_t;

    regs_t             r_d, r_q;
    logic [IDX_W-1:0]  idx;
    logic [N-1:0]      cur_lvl, prev_lvl;
    logic [N-1:0]      clr_rise, clr_fall, clr_high, clr_low;

    assign idx = bus_addr[ADDR_W-1:2];

    function automatic logic [N-1:0] clear_mask(input logic wr, input logic [IDX_W-1:0] a,
                                                input reg_idx_e which, input logic [N-1:0] data);
        return (wr && a == IDX_W'(which)) ? data : '0;
    endfunction

    always_comb begin
        cur_lvl  = in_sync & r_q.bank[RG_IN_EN];
        prev_lvl = r_q.bank[RG_IN_VAL];
        clr_rise = clear_mask(bus_wr, idx, RG_RISE_IP, bus_wdata);
        clr_fall = clear_mask(bus_wr, idx, RG_FALL_IP, bus_wdata);
        clr_high = clear_mask(bus_wr, idx, RG_HIGH_IP, bus_wdata);
        clr_low  = clear_mask(bus_wr, idx, RG_LOW_IP,  bus_wdata);

        r_d = r_q;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (bus_wr && idx == IDX_W'(k)) r_d.bank[k] = bus_wdata;
        end
        // Sampled and pending words override any plain store above.
        r_d.bank[RG_IN_VAL]  = cur_lvl;
        r_d.bank[RG_RISE_IP] = (r_q.bank[RG_RISE_IP] & ~clr_rise) | (cur_lvl & ~prev_lvl);
        r_d.bank[RG_FALL_IP] = (r_q.bank[RG_FALL_IP] & ~clr_fall) | (~cur_lvl & prev_lvl);
        r_d.bank[RG_HIGH_IP] = (r_q.bank[RG_HIGH_IP] & ~clr_high) | cur_lvl;
        r_d.bank[RG_LOW_IP]  = (r_q.bank[RG_LOW_IP]  & ~clr_low)  | ~cur_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (idx == IDX_W'(k)) bus_rdata = r_q.bank[k];
        end
    end

    assign out_en    = r_q.bank[RG_OUT_EN];
    assign out_val   = r_q.bank[RG_OUT_VAL];
    assign pull_en   = r_q.bank[RG_PULL];
    assign drive_sel = r_q.bank[RG_DRIVE];
    assign alt_en    = r_q.bank[RG_ALT_EN];
    assign alt_sel   = r_q.bank[RG_ALT_SEL];
    assign out_inv   = r_q.bank[RG_OUT_INV];
    assign irq = (r_q.bank[RG_RISE_IP] & r_q.bank[RG_RISE_IE])
               | (r_q.bank[RG_FALL_IP] & r_q.bank[RG_FALL_IE])
               | (r_q.bank[RG_HIGH_IP] & r_q.bank[RG_HIGH_IE])
               | (r_q.bank[RG_LOW_IP]  & r_q.bank[RG_LOW_IE]);

    assert_inval_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.bank[RG_IN_VAL] & ~$past(r_q.bank[RG_IN_EN])) == '0);

    assert_rise_caught_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.bank[RG_IN_VAL] & ~$past(r_q.bank[RG_IN_VAL])) & ~r_q.bank[RG_RISE_IP]) == '0);

    assert_fall_caught_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((~r_q.bank[RG_IN_VAL] & $past(r_q.bank[RG_IN_VAL])) & ~r_q.bank[RG_FALL_IP]) == '0);

    assert_level_caught_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~r_q.bank[RG_IN_VAL] & ~r_q.bank[RG_LOW_IP])
                 | (r_q.bank[RG_IN_VAL] & ~r_q.bank[RG_HIGH_IP])) == '0);

    assert_rise_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == IDX_W'(RG_RISE_IP)) |=>
        (r_q.bank[RG_RISE_IP] & $past(bus_wdata)
         & ~(r_q.bank[RG_IN_VAL] & ~$past(r_q.bank[RG_IN_VAL]))) == '0);

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.bank[RG_RISE_IE] | r_q.bank[RG_FALL_IE] | r_q.bank[RG_HIGH_IE]
          | r_q.bank[RG_LOW_IE]) == '0) |-> (irq == '0));
endmodule

// File: rtl/pinio_mux.sv
`timescale 1ns/1ps
module pinio_mux #(
    parameter int N = 32
) (
    input  logic [N-1:0] out_val,
    input  logic [N-1:0] out_en,
    input  logic [N-1:0] out_inv,
    input  logic [N-1:0] alt_en,
    input  logic [N-1:0] alt_sel,
    input  logic [N-1:0] alt0_out,
    input  logic [N-1:0] alt0_oe,
    input  logic [N-1:0] alt1_out,
    input  logic [N-1:0] alt1_oe,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] pad_oe
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic alt_lvl, alt_dir, src_lvl;
        assign alt_lvl    = alt_sel[i] ? alt1_out[i] : alt0_out[i];
        assign alt_dir    = alt_sel[i] ? alt1_oe[i]  : alt0_oe[i];
        assign src_lvl    = alt_en[i]  ? alt_lvl     : out_val[i];
        assign pad_out[i] = src_lvl ^ out_inv[i];
        assign pad_oe[i]  = alt_en[i]  ? alt_dir     : out_en[i];
    end
endmodule

// File: rtl/pinio_ctrl.sv
`timescale 1ns/1ps
module pinio_ctrl #(
    parameter int N      = 32,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    output logic [N-1:0]      pad_pull,
    output logic [N-1:0]      pad_drive,
    input  logic [N-1:0]      alt0_out,
    input  logic [N-1:0]      alt0_oe,
    input  logic [N-1:0]      alt1_out,
    input  logic [N-1:0]      alt1_oe,
    output logic [N-1:0]      irq
);
    logic [N-1:0] in_sync, out_en, out_val, alt_en, alt_sel, out_inv;

    pinio_sync #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(in_sync)
    );

    pinio_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_sync(in_sync),
        .out_en(out_en), .out_val(out_val), .pull_en(pad_pull), .drive_sel(pad_drive),
        .alt_en(alt_en), .alt_sel(alt_sel), .out_inv(out_inv), .irq(irq)
    );

    pinio_mux #(.N(N)) u_mux (
        .out_val(out_val), .out_en(out_en), .out_inv(out_inv),
        .alt_en(alt_en), .alt_sel(alt_sel),
        .alt0_out(alt0_out), .alt0_oe(alt0_oe), .alt1_out(alt1_out), .alt1_oe(alt1_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );
endmodule

// File: tb/pinio_ctrl_test.sv
`timescale 1ns/1ps
module pinio_ctrl_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0, alt0_out = '0, alt0_oe = '0, alt1_out = '0, alt1_oe = '0;
    logic [31:0] pad_out, pad_oe, pad_pull, pad_drive, irq;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    bit model_on = 0;

    always #2 clk = ~clk;

    pinio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull), .pad_drive(pad_drive),
        .alt0_out(alt0_out), .alt0_oe(alt0_oe), .alt1_out(alt1_out), .alt1_oe(alt1_oe),
        .irq(irq)
    );

    // Behavioural reference model
    logic [31:0] m [0:16];
    logic [31:0] ms1, ms2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 17; k++) m[k] = '0;
            ms1 = '0; ms2 = '0;
        end else begin
            logic [31:0] lv, old, c7, c9, c11, c13;
            int a;
            a   = int'(bus_addr[6:2]);
            lv  = ms2 & m[1];
            old = m[0];
            c7 = 0; c9 = 0; c11 = 0; c13 = 0;
            if (bus_wr) begin
                case (a)
                    7:  c7  = bus_wdata;
                    9:  c9  = bus_wdata;
                    11: c11 = bus_wdata;
                    13: c13 = bus_wdata;
                    0:  ;
                    default: if (a < 17) m[a] = bus_wdata;
                endcase
            end
            m[7]  = (m[7]  & ~c7)  | (lv & ~old);
            m[9]  = (m[9]  & ~c9)  | (~lv & old);
            m[11] = (m[11] & ~c11) | lv;
            m[13] = (m[13] & ~c13) | ~lv;
            m[0]  = lv;
            ms2 = ms1;
            ms1 = pad_in;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, midway to the next rising edge
    always @(negedge clk) begin
        #1.5;
        if (model_on && rst_n) begin
            logic [31:0] eo, eoe, rd;
            eo  = ((m[14] & ((m[15] & alt1_out) | (~m[15] & alt0_out))) | (~m[14] & m[3])) ^ m[16];
            eoe = (m[14] & ((m[15] & alt1_oe) | (~m[15] & alt0_oe))) | (~m[14] & m[2]);
            rd  = (int'(bus_addr[6:2]) < 17) ? m[bus_addr[6:2]] : 32'h0;
            check("R5 pad_out", pad_out, eo);
            check("R6 pad_oe", pad_oe, eoe);
            check("R7 pad_pull", pad_pull, m[4]);
            check("R7 pad_drive", pad_drive, m[5]);
            check("R11 irq", irq, (m[6]&m[7])|(m[8]&m[9])|(m[10]&m[11])|(m[12]&m[13]));
            check("R2 bus_rdata", bus_rdata, rd);
        end
    end

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 7'(idx * 4); bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] addr, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = addr;
        #1.5;
        check(tag, bus_rdata, exp);
    endtask

    function automatic logic [31:0] pat(input int idx);
        return 32'h9E3779B9 * 32'(idx + 1);
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1.5;
        check("R1 pad_out", pad_out, 0);
        check("R1 pad_oe", pad_oe, 0);
        check("R1 pad_pull", pad_pull, 0);
        check("R1 irq", irq, 0);
        for (int k = 0; k < 17; k++) begin
            bus_addr = 7'(k * 4); #0.1;
            check("R1 reg read", bus_rdata, 0);
        end
        @(negedge clk);
        rst_n = 1;
        model_on = 1;

        // R3: read-back of every storage register, all bits
        for (int k = 1; k < 17; k++)
            if (!(k == 7 || k == 9 || k == 11 || k == 13)) wr(k, pat(k));
        for (int k = 1; k < 17; k++)
            if (!(k == 7 || k == 9 || k == 11 || k == 13)) rd_chk("R3 readback", 7'(k * 4), pat(k));

        // R2: out-of-range index, ignored low address bits
        wr(17, 32'hFFFFFFFF);
        rd_chk("R2 idx17 reads 0", 7'h44, 0);
        rd_chk("R2 idx16 untouched", 7'h40, pat(16));
        rd_chk("R2 byte bits ignored", 7'h43, pat(16));

        // R4: three-edge input latency with gating
        wr(1, 32'hFFFF0000);
        @(negedge clk);
        pad_in = 32'h12345678; bus_addr = 7'h00;
        #1.5 check("R4 edge0", bus_rdata, 0);
        @(negedge clk); #1.5 check("R4 edge1", bus_rdata, 0);
        @(negedge clk); #1.5 check("R4 edge2", bus_rdata, 0);
        @(negedge clk); #1.5 check("R4 edge3 gated", bus_rdata, 32'h12340000);
        wr(0, 32'hFFFFFFFF);
        rd_chk("R4 write ignored", 7'h00, 32'h12340000);

        // R8 / R10 edge pendings
        rd_chk("R8 rise set", 7'h1C, 32'h12340000);
        wr(7, 32'hFFFFFFFF);
        rd_chk("R10 rise cleared", 7'h1C, 0);
        @(negedge clk); pad_in = 0;
        repeat (4) @(negedge clk);
        rd_chk("R8 fall set", 7'h24, 32'h12340000);
        wr(11, 32'hFFFFFFFF);
        rd_chk("R9 high cleared once low", 7'h2C, 0);
        wr(13, 32'hFFFFFFFF);
        rd_chk("R10 low set wins over clear", 7'h34, 32'hFFFFFFFF);
        wr(13, 32'h00000000);
        rd_chk("R10 zero write keeps", 7'h34, 32'hFFFFFFFF);

        // R11 interrupt combine
        wr(6, 0); wr(8, 0); wr(10, 0); wr(12, 0);
        #1.5 check("R11 no enables", irq, 0);
        wr(12, 32'h00000001);
        #1.5 check("R11 low enabled pin0", irq, 32'h00000001);
        wr(8, 32'h00340000);
        #1.5 check("R11 fall enabled", irq, 32'h00340001);

        // R5 / R6 / R7 routing
        wr(14, 0); wr(3, 32'hA5A50F0F); wr(16, 32'hFFFF0000); wr(2, 32'h0000FFFF);
        #1.5 check("R5 sw xor", pad_out, 32'h5A5A0F0F);
        check("R6 sw oe", pad_oe, 32'h0000FFFF);
        @(negedge clk);
        alt0_out = 32'h11111111; alt1_out = 32'h22222222;
        alt0_oe = 32'hF0F0F0F0; alt1_oe = 32'h0F0F0F0F;
        wr(15, 32'hFF00FF00); wr(14, 32'hFFFF0000);
        #1.5 check("R5 alt mix", pad_out, 32'hDDEE0F0F);
        check("R6 alt mix", pad_oe, 32'h0FF0FFFF);
        wr(4, 32'h00FF00FF);
        #1.5 check("R7 pull", pad_pull, 32'h00FF00FF);

        // Mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            bus_wr    = ($urandom_range(0, 2) == 0);
            bus_addr  = 7'($urandom_range(0, 18) * 4 + $urandom_range(0, 3));
            bus_wdata = $urandom;
            if ($urandom_range(0, 3) == 0) pad_in = $urandom;
            alt0_out = $urandom; alt1_out = $urandom;
            alt0_oe  = $urandom; alt1_oe  = $urandom;
        end
        @(negedge clk); bus_wr = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule